// File: doc/BRIEF.md
# Header-CRC Byte Delineator

This block recovers frame boundaries from a payload stream that arrives one byte per clock. An upstream stage has already aligned the stream to bytes and located the payload. Every frame starts with an 8-byte header, and a 2-byte CRC-16 computed over those 8 bytes follows it directly. The block holds the ten most recent bytes in a window and tests a new candidate header on every accepted byte. A candidate can therefore be found at any byte offset, and no search at bit level is needed.

After a candidate passes, the block reads the header's length field. That field tells it where the next header must sit, so the block jumps there and checks that one position only. It does not search the bytes in between. Two confirmations in a row at the predicted positions move the block into sync. Once in sync, three predicted headers in a row that fail the CRC send it back to a free byte-by-byte search. The outputs are:

- a one-cycle header pulse, together with the length and type fields that were extracted;
- an in-sync flag;
- a strobe and the byte itself for every payload byte between a header's CRC and the next header.

Top module: `header_crc_delineator`

## Requirements
- R1: After reset, hdr_start, payload_valid and in_sync are 0, and hdr_len and hdr_type are 0.
- R2: A header is accepted only if a specific CRC check passes. The CRC uses polynomial 0x1021 and a 16-bit register preset to 0xFFFF. Each byte is shifted in most significant bit first, with no reflection and no final XOR. The check runs over the 8 header bytes, and its result must equal the two following bytes read as a big-endian value, with the first of the two as the high byte. A frame whose CRC bytes are wrong produces no hdr_start.
- R3: While searching, a candidate is tested at every accepted byte, so a header is found after any number of leading junk bytes. hdr_start is high for exactly one cycle, in the second cycle after the clock edge that accepts the last CRC byte.
- R4: hdr_len is header bytes 0 and 1, big-endian. hdr_type is header bytes 2 and 3, big-endian. Bytes 4 to 7 are covered by the CRC but not decoded. Both outputs update together with hdr_start and hold until the next accepted header.
- R5: Once a header is accepted, the next header check happens only where the next frame's last CRC byte is due, which is hdr_len + 10 accepted bytes later. The hdr_len bytes that follow the CRC are each flagged by payload_valid, carry the byte on payload_byte, and have the same two-cycle latency as hdr_start.
- R6: A length of 0 places the next header directly after the current CRC bytes.
- R7: in_sync rises with the hdr_start of the second consecutive header that passes at a predicted position after the search found one. It does not rise before that.
- R8: If the first predicted header after a search fails its CRC, the block goes back to searching. It gives no hdr_start and no payload_valid for that frame, and it can then find the next valid header.
- R9: While in sync, a failed predicted header gives no hdr_start, and the next position is predicted with the last good length. One or two failures in a row keep in_sync high, and any good header clears that count. The third consecutive failure drops in_sync.
- R10: Cycles with in_valid low do not count as bytes: positions and predictions are counted in accepted bytes only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | in_byte carries a stream byte this cycle |
| in_byte | input | 8 | Byte-aligned payload stream |
| hdr_start | output | 1 | One-cycle pulse on each accepted header |
| hdr_len | output | 16 | Length field of the last accepted header |
| hdr_type | output | 16 | Type field of the last accepted header |
| in_sync | output | 1 | Frame delineation locked |
| payload_valid | output | 1 | payload_byte is a byte between headers |
| payload_byte | output | 8 | Payload byte flagged by payload_valid |

## Verification
The first patterns place valid frames behind a junk prefix and use a mix of zero and non-zero lengths. These show that a header is found at any byte offset, that the skip lands exactly on the next header, and that payload bytes are counted and summed correctly. A lone frame with a corrupted CRC separates a real CRC check from simple pattern matching. A failure right after acquisition tests the confirmation stage separately from the sync stage. A bad-bad-good-bad-bad-bad run while in sync tests that misses are counted as consecutive and not in total. Finally, repeating the valid frames with an idle cycle after every byte shows that only accepted bytes advance the position count.

// File: rtl/hcd_pkg.sv
package hcd_pkg;
   typedef enum logic [1:0] {
      ST_HUNT    = 2'd0,
      ST_PRESYNC = 2'd1,
      ST_SYNC    = 2'd2
   } hcd_state_e;
endpackage

// File: rtl/hcd_window.sv
module hcd_window #(
   parameter int BYTE_W = 8,
   parameter int DEPTH  = 10
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   input  logic [BYTE_W-1:0]         in_byte,
   output logic [DEPTH*BYTE_W-1:0]   win_flat,
   output logic                      full,
   output logic                      fresh
);
   localparam int FW = $clog2(DEPTH + 1);
   localparam logic [FW-1:0] FULL_CNT = FW'(DEPTH);

   logic [BYTE_W-1:0] stg [DEPTH];
   logic [FW-1:0]     fill;

   // stage 0 holds the newest byte, stage DEPTH-1 the oldest
   for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        stg[0] <= '0;
            else if (in_valid) stg[0] <= in_byte;
         end
      end else begin : g_body
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        stg[i] <= '0;
            else if (in_valid) stg[i] <= stg[i-1];
         end
      end
      assign win_flat[i*BYTE_W +: BYTE_W] = stg[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill  <= '0;
         fresh <= 1'b0;
      end else begin
         fresh <= in_valid;
         if (in_valid && fill != FULL_CNT) fill <= fill + 1'b1;
      end
   end

   assign full = (fill == FULL_CNT);
endmodule

// File: rtl/hcd_crc_check.sv
module hcd_crc_check #(
   parameter int              BYTE_W    = 8,
   parameter int              HDR_BYTES = 8,
   parameter int              CRC_W     = 16,
   parameter int              LEN_W     = 16,
   parameter int              TYPE_W    = 16,
   parameter logic [CRC_W-1:0] POLY     = 16'h1021,
   parameter logic [CRC_W-1:0] INIT     = 16'hFFFF,
   localparam int             WIN_BYTES = HDR_BYTES + CRC_W / BYTE_W
) (
   input  logic [WIN_BYTES*BYTE_W-1:0] win_flat,
   output logic                        match,
   output logic [LEN_W-1:0]            len_f,
   output logic [TYPE_W-1:0]           type_f
);
   localparam int TOP = WIN_BYTES * BYTE_W;

   logic [CRC_W-1:0]  crc;
   logic [BYTE_W-1:0] hb;

   // header byte k (k = 0 first on the wire) sits at window slot WIN_BYTES-1-k
   always_comb begin
      crc = INIT;
      hb  = '0;
      for (int k = 0; k < HDR_BYTES; k++) begin
         hb  = win_flat[(WIN_BYTES-1-k)*BYTE_W +: BYTE_W];
         crc = crc ^ (CRC_W'(hb) << (CRC_W - BYTE_W));
         for (int b = 0; b < BYTE_W; b++) begin
            crc = crc[CRC_W-1] ? ((crc << 1) ^ POLY) : (crc << 1);
         end
      end
   end

   // trailing CRC bytes: the earlier one lands in the higher bits (big-endian)
   assign match  = (crc == win_flat[CRC_W-1:0]);
   assign len_f  = win_flat[TOP-1 -: LEN_W];
   assign type_f = win_flat[TOP-1-LEN_W -: TYPE_W];
endmodule

// File: rtl/hcd_track.sv
module hcd_track
   import hcd_pkg::*;
#(
   parameter int BYTE_W     = 8,
   parameter int LEN_W      = 16,
   parameter int TYPE_W     = 16,
   parameter int WIN_BYTES  = 10,
   parameter int CONFIRM    = 2,
   parameter int MISS_LIMIT = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fresh,
   input  logic              full,
   input  logic              match,
   input  logic [LEN_W-1:0]  len_f,
   input  logic [TYPE_W-1:0] type_f,
   input  logic [BYTE_W-1:0] newest,
   output logic              hdr_start,
   output logic [LEN_W-1:0]  hdr_len,
   output logic [TYPE_W-1:0] hdr_type,
   output logic              in_sync,
   output logic              pl_valid,
   output logic [BYTE_W-1:0] pl_byte
);
   localparam int RW = LEN_W + 1;
   localparam int CW = $clog2(CONFIRM + 1);
   localparam int MW = $clog2(MISS_LIMIT + 1);
   localparam logic [RW-1:0] WIN_R   = RW'(WIN_BYTES);
   localparam logic [RW-1:0] ONE_R   = RW'(1);
   localparam logic [CW-1:0] CONF_LAST = CW'(CONFIRM - 1);
   localparam logic [MW-1:0] MISS_LAST = MW'(MISS_LIMIT - 1);

   hcd_state_e       state;
   logic [RW-1:0]    rem;
   logic [LEN_W-1:0] last_len;
   logic [CW-1:0]    good_cnt;
   logic [MW-1:0]    miss_cnt;
   logic             at_slot;
   logic             take;

   assign at_slot = fresh && (state != ST_HUNT) && (rem == ONE_R);
   assign take    = fresh && match &&
                    ((state == ST_HUNT && full) || (state != ST_HUNT && rem == ONE_R));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_HUNT;
         rem       <= '0;
         last_len  <= '0;
         good_cnt  <= '0;
         miss_cnt  <= '0;
         hdr_start <= 1'b0;
         hdr_len   <= '0;
         hdr_type  <= '0;
         pl_valid  <= 1'b0;
         pl_byte   <= '0;
      end else begin
         hdr_start <= 1'b0;
         pl_valid  <= 1'b0;
         if (take) begin
            hdr_start <= 1'b1;
            hdr_len   <= len_f;
            hdr_type  <= type_f;
            last_len  <= len_f;
            rem       <= RW'(len_f) + WIN_R;
            miss_cnt  <= '0;
            unique case (state)
               ST_HUNT: begin
                  state    <= ST_PRESYNC;
                  good_cnt <= '0;
               end
               ST_PRESYNC: begin
                  if (good_cnt == CONF_LAST) begin
                     state    <= ST_SYNC;
                     good_cnt <= '0;
                  end else begin
                     good_cnt <= good_cnt + 1'b1;
                  end
               end
               default: ;
            endcase
         end else if (at_slot) begin
            if (state == ST_PRESYNC || miss_cnt == MISS_LAST) begin
               state    <= ST_HUNT;
               miss_cnt <= '0;
               good_cnt <= '0;
            end else begin
               miss_cnt <= miss_cnt + 1'b1;
               rem      <= RW'(last_len) + WIN_R;
            end
         end else if (fresh && state != ST_HUNT) begin
            rem <= rem - 1'b1;
            if (rem > WIN_R) begin
               pl_valid <= 1'b1;
               pl_byte  <= newest;
            end
         end
      end
   end

   assign in_sync = (state == ST_SYNC);
endmodule

// File: rtl/header_crc_delineator.sv
module header_crc_delineator #(
   parameter int              BYTE_W     = 8,
   parameter int              HDR_BYTES  = 8,
   parameter int              CRC_W      = 16,
   parameter int              LEN_W      = 16,
   parameter int              TYPE_W     = 16,
   parameter logic [CRC_W-1:0] CRC_POLY  = 16'h1021,
   parameter logic [CRC_W-1:0] CRC_INIT  = 16'hFFFF,
   parameter int              CONFIRM    = 2,
   parameter int              MISS_LIMIT = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [BYTE_W-1:0] in_byte,
   output logic              hdr_start,
   output logic [LEN_W-1:0]  hdr_len,
   output logic [TYPE_W-1:0] hdr_type,
   output logic              in_sync,
   output logic              payload_valid,
   output logic [BYTE_W-1:0] payload_byte
);
   localparam int CRC_BYTES = CRC_W / BYTE_W;
   localparam int WIN_BYTES = HDR_BYTES + CRC_BYTES;

   if (CRC_W % BYTE_W != 0) begin : g_bad_crc_w
      $error("CRC width must be a whole number of bytes");
   end
   if (LEN_W + TYPE_W > HDR_BYTES * BYTE_W) begin : g_bad_fields
      $error("length and type fields do not fit in the header");
   end
   if (CONFIRM < 1 || MISS_LIMIT < 1) begin : g_bad_counts
      $error("confirm and miss limits must be at least 1");
   end

   logic [WIN_BYTES*BYTE_W-1:0] win_flat;
   logic                        full, fresh, match;
   logic [LEN_W-1:0]            len_f;
   logic [TYPE_W-1:0]           type_f;

   hcd_window #(.BYTE_W(BYTE_W), .DEPTH(WIN_BYTES)) u_win (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
      .win_flat(win_flat), .full(full), .fresh(fresh)
   );

   hcd_crc_check #(
      .BYTE_W(BYTE_W), .HDR_BYTES(HDR_BYTES), .CRC_W(CRC_W),
      .LEN_W(LEN_W), .TYPE_W(TYPE_W), .POLY(CRC_POLY), .INIT(CRC_INIT)
   ) u_crc (
      .win_flat(win_flat), .match(match), .len_f(len_f), .type_f(type_f)
   );

   hcd_track #(
      .BYTE_W(BYTE_W), .LEN_W(LEN_W), .TYPE_W(TYPE_W),
      .WIN_BYTES(WIN_BYTES), .CONFIRM(CONFIRM), .MISS_LIMIT(MISS_LIMIT)
   ) u_trk (
      .clk(clk), .rst_n(rst_n), .fresh(fresh), .full(full), .match(match),
      .len_f(len_f), .type_f(type_f), .newest(win_flat[BYTE_W-1:0]),
      .hdr_start(hdr_start), .hdr_len(hdr_len), .hdr_type(hdr_type),
      .in_sync(in_sync), .pl_valid(payload_valid), .pl_byte(payload_byte)
   );
endmodule

// File: rtl/hcd_checker.sv
module hcd_checker (
   input logic clk,
   input logic rst_n,
   input logic in_valid,
   input logic hdr_start,
   input logic payload_valid,
   input logic in_sync
);
   // R3: a header pulse lasts one cycle
   a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_start |=> !hdr_start);

   // R5: a byte is never both a header end and payload
   a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(hdr_start && payload_valid));

   // R7: sync is only gained on an accepted header
   a_r7_sync_on_hdr: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_sync) |-> hdr_start);

   // R9: sync is lost only on a failed header
   a_r9_drop_no_hdr: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(in_sync) |-> !hdr_start);

   // R10: every flag traces back to a byte accepted two edges earlier
   a_r10_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_start || payload_valid) |-> $past(in_valid, 2));
endmodule

bind header_crc_delineator hcd_checker u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .hdr_start(hdr_start),
   .payload_valid(payload_valid), .in_sync(in_sync)
);

// File: tb/sim_header_crc_delineator.sv
module sim_header_crc_delineator;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_byte = 8'h00;
   logic        hdr_start, in_sync, payload_valid;
   logic [15:0] hdr_len, hdr_type;
   logic [7:0]  payload_byte;

   header_crc_delineator u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
      .hdr_start(hdr_start), .hdr_len(hdr_len), .hdr_type(hdr_type),
      .in_sync(in_sync), .payload_valid(payload_valid), .payload_byte(payload_byte)
   );

   always #5 clk = ~clk;

   int n_checks = 0, n_fail = 0;
   int byte_idx = 0, prev_idx = -1;
   int hdr_count = 0, pl_count = 0, pl_sum = 0, exp_pl_sum = 0;
   int          hdr_at   [16];
   logic [15:0] len_at   [16];
   logic [15:0] type_at  [16];
   logic        sync_at  [16];

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] crc16(input logic [7:0] h [8]);
      logic [15:0] c = 16'hFFFF;
      for (int k = 0; k < 8; k++) begin
         c = c ^ {h[k], 8'h00};
         for (int b = 0; b < 8; b++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
      end
      return c;
   endfunction

   // one clock: drive at negedge, observe the result of the byte from the previous cycle
   task automatic tick(input logic v, input logic [7:0] b);
      in_valid = v;
      in_byte  = b;
      @(negedge clk);
      if (hdr_start) begin
         if (hdr_count < 16) begin
            hdr_at[hdr_count]  = prev_idx;
            len_at[hdr_count]  = hdr_len;
            type_at[hdr_count] = hdr_type;
            sync_at[hdr_count] = in_sync;
         end
         hdr_count++;
      end
      if (payload_valid) begin
         pl_count++;
         pl_sum += int'(payload_byte);
      end
      prev_idx = v ? byte_idx : -1;
      if (v) byte_idx++;
   endtask

   task automatic put(input logic [7:0] b, input bit gap);
      tick(1'b1, b);
      if (gap) tick(1'b0, 8'h00);
   endtask

   task automatic send_frame(input logic [15:0] len, input logic [15:0] typ,
                             input bit bad, input bit gap, output int crc_end);
      logic [7:0]  h [8];
      logic [15:0] c;
      h[0] = len[15:8]; h[1] = len[7:0]; h[2] = typ[15:8]; h[3] = typ[7:0];
      for (int k = 4; k < 8; k++) h[k] = 8'hC0 + 8'(k);
      c = crc16(h);
      if (bad) c = c ^ 16'h0001;
      for (int k = 0; k < 8; k++) put(h[k], gap);
      put(c[15:8], gap);
      crc_end = byte_idx;
      put(c[7:0], gap);
      for (int k = 0; k < int'(len); k++) begin
         logic [7:0] p = 8'h5A ^ 8'(k * 7);
         if (!bad) exp_pl_sum += int'(p);
         put(p, gap);
      end
   endtask

   task automatic flush(input int n);
      for (int k = 0; k < n; k++) tick(1'b0, 8'h00);
   endtask

   task automatic do_reset;
      in_valid = 1'b0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      byte_idx = 0; prev_idx = -1;
      hdr_count = 0; pl_count = 0; pl_sum = 0; exp_pl_sum = 0;
   endtask

   task automatic t_reset;
      do_reset();
      check(hdr_start == 1'b0, "R1", "hdr_start after reset", int'(hdr_start), 0);
      check(payload_valid == 1'b0, "R1", "payload_valid after reset", int'(payload_valid), 0);
      check(in_sync == 1'b0, "R1", "in_sync after reset", int'(in_sync), 0);
      check(hdr_len == 16'd0 && hdr_type == 16'd0, "R1", "fields after reset",
            int'(hdr_len) + int'(hdr_type), 0);
   endtask

   task automatic t_bad_crc;
      int e;
      do_reset();
      send_frame(16'd4, 16'h1234, 1'b1, 1'b0, e);
      flush(3);
      check(hdr_count == 0, "R2", "headers from corrupt CRC", hdr_count, 0);
      check(in_sync == 1'b0, "R2", "in_sync after corrupt CRC", int'(in_sync), 0);
   endtask

   task automatic t_acquire;
      int ea, eb, ec, ed;
      do_reset();
      for (int k = 0; k < 5; k++) put(8'h11 * 8'(k + 1), 1'b0);
      send_frame(16'd3, 16'h88B5, 1'b0, 1'b0, ea);
      send_frame(16'd0, 16'h0800, 1'b0, 1'b0, eb);
      send_frame(16'd5, 16'h86DD, 1'b0, 1'b0, ec);
      send_frame(16'd2, 16'hABCD, 1'b0, 1'b0, ed);
      flush(3);
      check(hdr_count == 4, "R5", "header count", hdr_count, 4);
      check(hdr_at[0] == ea, "R3", "first header after junk", hdr_at[0], ea);
      check(len_at[0] == 16'd3 && type_at[0] == 16'h88B5, "R4", "fields of first header",
            int'(type_at[0]), 'h88B5);
      check(hdr_at[1] == eb, "R6", "zero-length header position", hdr_at[1], eb);
      check(hdr_at[2] == ec, "R6", "header right after zero length", hdr_at[2], ec);
      check(hdr_at[3] == ed && len_at[3] == 16'd2, "R5", "skip to last header", hdr_at[3], ed);
      check(sync_at[1] == 1'b0, "R7", "sync after one confirmation", int'(sync_at[1]), 0);
      check(sync_at[2] == 1'b1, "R7", "sync after two confirmations", int'(sync_at[2]), 1);
      check(pl_count == 10, "R5", "payload byte count", pl_count, 10);
      check(pl_sum == exp_pl_sum, "R5", "payload byte sum", pl_sum, exp_pl_sum);
      check(hdr_type == 16'hABCD, "R4", "type held after last header", int'(hdr_type), 'hABCD);
   endtask

   task automatic t_presync_fail;
      int ea, eb, ec, ed, ee;
      do_reset();
      send_frame(16'd4, 16'h0101, 1'b0, 1'b0, ea);
      send_frame(16'd4, 16'h0202, 1'b1, 1'b0, eb);
      flush(2);
      check(in_sync == 1'b0, "R8", "in_sync after early miss", int'(in_sync), 0);
      check(hdr_count == 1, "R8", "no pulse for failed header", hdr_count, 1);
      send_frame(16'd4, 16'h0303, 1'b0, 1'b0, ec);
      send_frame(16'd4, 16'h0404, 1'b0, 1'b0, ed);
      send_frame(16'd4, 16'h0505, 1'b0, 1'b0, ee);
      flush(3);
      check(hdr_count == 4 && hdr_at[1] == ec, "R8", "reacquired header", hdr_at[1], ec);
      check(in_sync == 1'b1, "R8", "sync after reacquire", int'(in_sync), 1);
      check(pl_count == 16 && pl_sum == exp_pl_sum, "R8", "payload of failed frame not flagged",
            pl_count, 16);
   endtask

   task automatic t_sync_loss;
      int e;
      do_reset();
      for (int k = 0; k < 3; k++) send_frame(16'd6, 16'h0A0A, 1'b0, 1'b0, e);
      flush(1);
      check(in_sync == 1'b1, "R9", "locked before misses", int'(in_sync), 1);
      send_frame(16'd6, 16'h0B0B, 1'b1, 1'b0, e);
      send_frame(16'd6, 16'h0B0B, 1'b1, 1'b0, e);
      flush(1);
      check(in_sync == 1'b1, "R9", "sync kept after two misses", int'(in_sync), 1);
      check(hdr_count == 3, "R9", "no pulse for missed headers", hdr_count, 3);
      send_frame(16'd6, 16'h0C0C, 1'b0, 1'b0, e);
      send_frame(16'd6, 16'h0B0B, 1'b1, 1'b0, e);
      send_frame(16'd6, 16'h0B0B, 1'b1, 1'b0, e);
      flush(1);
      check(hdr_count == 4 && in_sync == 1'b1, "R9", "good header cleared miss count",
            int'(in_sync), 1);
      send_frame(16'd6, 16'h0B0B, 1'b1, 1'b0, e);
      flush(2);
      check(in_sync == 1'b0, "R9", "sync lost on third consecutive miss", int'(in_sync), 0);
   endtask

   task automatic t_gaps;
      int ea, eb, ec;
      do_reset();
      put(8'h77, 1'b1);
      send_frame(16'd2, 16'h0E0E, 1'b0, 1'b1, ea);
      send_frame(16'd1, 16'h0F0F, 1'b0, 1'b1, eb);
      send_frame(16'd3, 16'h1010, 1'b0, 1'b1, ec);
      flush(3);
      check(hdr_count == 3 && hdr_at[2] == ec, "R10", "positions with idle cycles",
            hdr_at[2], ec);
      check(in_sync == 1'b1, "R10", "sync with idle cycles", int'(in_sync), 1);
      check(pl_count == 6 && pl_sum == exp_pl_sum, "R10", "payload with idle cycles",
            pl_count, 6);
   endtask

   initial begin
      #(200000 * 10);
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_bad_crc();
      t_acquire();
      t_presync_fail();
      t_sync_loss();
      t_gaps();
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end
endmodule